// File: doc/BRIEF.md
# On-Demand Clock Request Gating Network

This block turns clock requests from peripherals into enables for three layers of clock gating. The layers are the bus-clock gates in front of each peripheral, the generic clock generators, and the clock sources that feed those generators. Each peripheral may ask for two things: its bus clock, and the generic clock of the one generator it is mapped to. A generator is enabled when something downstream wants it, and a source is enabled when a generator that is enabled this cycle is mapped to it. The current sleep level and the per-generator and per-source run-in-standby and on-demand flags then decide how strictly these demands are applied.

Generator 0 is special because it drives the main clock. It stays on in active and idle levels. In standby it is kept on whenever any peripheral asks for its bus clock, because bus clocks reach requesters in standby only through this generator. Every enable is computed combinationally from the current inputs and registered once, so every output follows its inputs after exactly one clock edge.

The mappings are packed select fields. A select value that does not name an existing generator or source connects its owner to nothing.

Top module: `clk_req_gate_net`

## Requirements
- R1: While `rst_n` is low, `bus_en`, `gen_en` and `src_en` are all zero.
- R2: Every enable output is registered. The value it takes at a rising edge is computed from the inputs present just before that edge, and it does not change between edges.
- R3: At sleep level 0 (active), every bit of `bus_en` is 1.
- R4: At sleep level 1 (full idle), `bus_en[p]` is 1 when peripheral p requests its bus clock or is marked in `FREE_BUS_MASK` as a peripheral without a request mechanism.
- R5: At sleep level 2 (lean idle) and at sleep level 3 (standby), `bus_en[p]` equals `periph_bus_req[p]`.
- R6: The demand on generator g is the OR of `periph_gen_req[p]` over every peripheral p whose select field `periph_gen_sel[p*GW +: GW]` equals g. A select value of N_GEN or more selects no generator. At levels 0 to 2, `gen_en[g]` for g ≥ 1 equals this demand.
- R7: At levels 0 to 2, `gen_en[0]` is 1.
- R8: At level 3, `gen_en[g]` for g ≥ 1 is `gen_run_stby[g]` AND the demand on g.
- R9: At level 3, `gen_en[0]` is 1 if any `periph_bus_req` bit is set. Otherwise it is `gen_run_stby[0]` AND the demand on generator 0.
- R10: The demand on source s is the OR of the generator enables computed in the same cycle over every generator g whose field `gen_src_sel[g*SW +: SW]` equals s. A value of N_SRC or more selects no source. With `src_on_demand[s]`=1, outside standby, `src_en[s]` equals this demand.
- R11: With `src_on_demand[s]`=0, outside standby, `src_en[s]` is 1.
- R12: At level 3, `src_en[s]` is 0 when `src_run_stby[s]` is 0. Otherwise it follows R10 or R11 according to `src_on_demand[s]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_lvl | input | 2 | 0 active, 1 full idle, 2 lean idle, 3 standby |
| periph_gen_req | input | N_PERIPH | Per-peripheral request for its generic clock |
| periph_bus_req | input | N_PERIPH | Per-peripheral request for its bus clock |
| periph_gen_sel | input | N_PERIPH*GW | Packed generator index of each peripheral |
| gen_src_sel | input | N_GEN*SW | Packed source index of each generator |
| gen_run_stby | input | N_GEN | Per-generator run-in-standby flag |
| src_run_stby | input | N_SRC | Per-source run-in-standby flag |
| src_on_demand | input | N_SRC | Per-source on-demand flag |
| bus_en | output | N_PERIPH | Bus-clock gate enables |
| gen_en | output | N_GEN | Generator enables |
| src_en | output | N_SRC | Clock source enables |

## Verification
The hardest situation to reach is a source that is held on only indirectly. In standby, a peripheral's bus request forces generator 0 on, and generator 0 in turn pulls an on-demand source on, while the peripheral's own generic request points at an unused select value. Reaching this needs a bus request, a select value out of range, an on-demand flag and run-in-standby flags all set together. The bench gets there by sweeping all four sleep levels, each with hundreds of pseudo-random vectors. These vectors cover every field, including the out-of-range select codes. A directed sequence then pins down the one-edge latency.

// File: rtl/cgn_pkg.sv
package cgn_pkg;

  typedef enum logic [1:0] {
    LVL_ACTIVE    = 2'd0,
    LVL_IDLE_FULL = 2'd1,
    LVL_IDLE_LEAN = 2'd2,
    LVL_STANDBY   = 2'd3
  } sleep_lvl_e;

  // Bus gate rule for one peripheral.
  function automatic logic bus_rule(sleep_lvl_e lvl, logic req, logic free_run);
    logic r;
    case (lvl)
      LVL_ACTIVE:    r = 1'b1;
      LVL_IDLE_FULL: r = req | free_run;
      default:       r = req;
    endcase
    return r;
  endfunction

  // Generator rule; is_main marks generator 0.
  function automatic logic gen_rule(logic is_main, sleep_lvl_e lvl, logic demand,
                                    logic any_bus, logic run_stby);
    logic r;
    if (lvl != LVL_STANDBY) r = is_main ? 1'b1 : demand;
    else if (is_main)       r = any_bus | (run_stby & demand);
    else                    r = run_stby & demand;
    return r;
  endfunction

  // Source rule.
  function automatic logic src_rule(sleep_lvl_e lvl, logic demand, logic on_demand,
                                    logic run_stby);
    logic r;
    if (lvl == LVL_STANDBY && !run_stby) r = 1'b0;
    else                                 r = on_demand ? demand : 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/cgn_bus_stage.sv
module cgn_bus_stage
  import cgn_pkg::*;
#(
  parameter int unsigned N_PERIPH      = 4,
  parameter logic [31:0] FREE_BUS_MASK = 32'h0000_0004
) (
  input  sleep_lvl_e          lvl,
  input  logic [N_PERIPH-1:0] bus_req,
  output logic [N_PERIPH-1:0] bus_nxt,
  output logic                any_bus
);
  localparam logic [N_PERIPH-1:0] FREE = FREE_BUS_MASK[N_PERIPH-1:0];

  for (genvar p = 0; p < N_PERIPH; p++) begin : g_bus
    assign bus_nxt[p] = bus_rule(lvl, bus_req[p], FREE[p]);
  end

  assign any_bus = |bus_req;
endmodule

// File: rtl/cgn_gen_stage.sv
module cgn_gen_stage
  import cgn_pkg::*;
#(
  parameter int unsigned N_PERIPH = 4,
  parameter int unsigned N_GEN    = 3,
  parameter int unsigned GW       = 2
) (
  input  sleep_lvl_e             lvl,
  input  logic [N_PERIPH-1:0]    gen_req,
  input  logic [N_PERIPH*GW-1:0] gen_sel,
  input  logic [N_GEN-1:0]       run_stby,
  input  logic                   any_bus,
  output logic [N_GEN-1:0]       demand,
  output logic [N_GEN-1:0]       gen_nxt
);
  for (genvar g = 0; g < N_GEN; g++) begin : g_gen
    logic hit;
    always_comb begin
      hit = 1'b0;
      for (int p = 0; p < N_PERIPH; p++) begin
        if (gen_req[p] && (gen_sel[p*GW +: GW] == GW'(g))) hit = 1'b1;
      end
    end
    assign demand[g]  = hit;
    assign gen_nxt[g] = gen_rule((g == 0), lvl, hit, any_bus, run_stby[g]);
  end
endmodule

// File: rtl/cgn_src_stage.sv
module cgn_src_stage
  import cgn_pkg::*;
#(
  parameter int unsigned N_GEN = 3,
  parameter int unsigned N_SRC = 3,
  parameter int unsigned SW    = 2
) (
  input  sleep_lvl_e          lvl,
  input  logic [N_GEN-1:0]    gen_nxt,
  input  logic [N_GEN*SW-1:0] src_sel,
  input  logic [N_SRC-1:0]    on_demand,
  input  logic [N_SRC-1:0]    run_stby,
  output logic [N_SRC-1:0]    demand,
  output logic [N_SRC-1:0]    src_nxt
);
  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    logic hit;
    always_comb begin
      hit = 1'b0;
      for (int g = 0; g < N_GEN; g++) begin
        if (gen_nxt[g] && (src_sel[g*SW +: SW] == SW'(s))) hit = 1'b1;
      end
    end
    assign demand[s]  = hit;
    assign src_nxt[s] = src_rule(lvl, hit, on_demand[s], run_stby[s]);
  end
endmodule

// File: rtl/clk_req_gate_net.sv
module clk_req_gate_net
  import cgn_pkg::*;
#(
  parameter int unsigned N_PERIPH      = 4,
  parameter int unsigned N_GEN         = 3,
  parameter int unsigned N_SRC         = 3,
  parameter logic [31:0] FREE_BUS_MASK = 32'h0000_0004,
  localparam int unsigned GW = (N_GEN > 1) ? $clog2(N_GEN) : 1,
  localparam int unsigned SW = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             sleep_lvl,
  input  logic [N_PERIPH-1:0]    periph_gen_req,
  input  logic [N_PERIPH-1:0]    periph_bus_req,
  input  logic [N_PERIPH*GW-1:0] periph_gen_sel,
  input  logic [N_GEN*SW-1:0]    gen_src_sel,
  input  logic [N_GEN-1:0]       gen_run_stby,
  input  logic [N_SRC-1:0]       src_run_stby,
  input  logic [N_SRC-1:0]       src_on_demand,
  output logic [N_PERIPH-1:0]    bus_en,
  output logic [N_GEN-1:0]       gen_en,
  output logic [N_SRC-1:0]       src_en
);
  sleep_lvl_e            lvl;
  logic [N_PERIPH-1:0]   bus_nxt;
  logic                  any_bus;
  logic [N_GEN-1:0]      gen_demand;
  logic [N_GEN-1:0]      gen_nxt;
  logic [N_SRC-1:0]      src_demand;
  logic [N_SRC-1:0]      src_nxt;

  assign lvl = sleep_lvl_e'(sleep_lvl);

  cgn_bus_stage #(.N_PERIPH(N_PERIPH), .FREE_BUS_MASK(FREE_BUS_MASK)) u_bus (
    .lvl(lvl), .bus_req(periph_bus_req), .bus_nxt(bus_nxt), .any_bus(any_bus)
  );

  cgn_gen_stage #(.N_PERIPH(N_PERIPH), .N_GEN(N_GEN), .GW(GW)) u_gen (
    .lvl(lvl), .gen_req(periph_gen_req), .gen_sel(periph_gen_sel),
    .run_stby(gen_run_stby), .any_bus(any_bus),
    .demand(gen_demand), .gen_nxt(gen_nxt)
  );

  cgn_src_stage #(.N_GEN(N_GEN), .N_SRC(N_SRC), .SW(SW)) u_src (
    .lvl(lvl), .gen_nxt(gen_nxt), .src_sel(gen_src_sel),
    .on_demand(src_on_demand), .run_stby(src_run_stby),
    .demand(src_demand), .src_nxt(src_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_en <= '0;
      gen_en <= '0;
      src_en <= '0;
    end else begin
      bus_en <= bus_nxt;
      gen_en <= gen_nxt;
      src_en <= src_nxt;
    end
  end
endmodule

// File: rtl/cgn_checker.sv
module cgn_checker #(
  parameter int unsigned N_PERIPH = 4,
  parameter int unsigned N_GEN    = 3,
  parameter int unsigned N_SRC    = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          sleep_lvl,
  input logic [N_PERIPH-1:0] periph_bus_req,
  input logic [N_GEN-1:0]    gen_run_stby,
  input logic [N_SRC-1:0]    src_run_stby,
  input logic [N_PERIPH-1:0] bus_en,
  input logic [N_GEN-1:0]    gen_en,
  input logic [N_SRC-1:0]    src_en,
  input logic [N_GEN-1:0]    gen_demand,
  input logic [N_GEN-1:0]    gen_nxt
);
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (bus_en == '0 && gen_en == '0 && src_en == '0));

  p_one_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> gen_en == $past(gen_nxt));

  p_bus_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(sleep_lvl) == 2'd0) |-> (&bus_en));

  p_bus_lean_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(sleep_lvl) >= 2'd2) |-> ((bus_en & ~$past(periph_bus_req)) == '0));

  p_gen_demand_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((gen_en[N_GEN-1:1] & ~$past(gen_demand[N_GEN-1:1])) == '0));

  p_main_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(sleep_lvl) != 2'd3) |-> gen_en[0]);

  p_gen_stby_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(sleep_lvl) == 2'd3)
      |-> ((gen_en[N_GEN-1:1] & ~$past(gen_run_stby[N_GEN-1:1])) == '0));

  p_main_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(sleep_lvl) == 2'd3 && $past(|periph_bus_req)) |-> gen_en[0]);

  p_src_stby_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(sleep_lvl) == 2'd3) |-> ((src_en & ~$past(src_run_stby)) == '0));
endmodule

bind clk_req_gate_net cgn_checker #(
  .N_PERIPH(N_PERIPH), .N_GEN(N_GEN), .N_SRC(N_SRC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_lvl(sleep_lvl), .periph_bus_req(periph_bus_req),
  .gen_run_stby(gen_run_stby), .src_run_stby(src_run_stby),
  .bus_en(bus_en), .gen_en(gen_en), .src_en(src_en),
  .gen_demand(gen_demand), .gen_nxt(gen_nxt)
);

// File: tb/clk_req_gate_net_test.sv
`timescale 1ns/1ps
module clk_req_gate_net_test;
  localparam int NP = 4, NG = 3, NS = 3, GW = 2, SW = 2;
  localparam logic [3:0] FREE = 4'b0100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] sleep_lvl = 2'd0;
  logic [NP-1:0] gen_req = '0, bus_req = '0;
  logic [NP*GW-1:0] gsel = '0;
  logic [NG*SW-1:0] ssel = '0;
  logic [NG-1:0] g_stby = '0;
  logic [NS-1:0] s_stby = '0, s_od = '0;
  logic [NP-1:0] bus_en;
  logic [NG-1:0] gen_en;
  logic [NS-1:0] src_en;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] lfsr = 32'h1234_5678;

  always #4 clk = ~clk;

  clk_req_gate_net #(.N_PERIPH(NP), .N_GEN(NG), .N_SRC(NS), .FREE_BUS_MASK(32'h4)) uut (
    .clk(clk), .rst_n(rst_n), .sleep_lvl(sleep_lvl), .periph_gen_req(gen_req),
    .periph_bus_req(bus_req), .periph_gen_sel(gsel), .gen_src_sel(ssel),
    .gen_run_stby(g_stby), .src_run_stby(s_stby), .src_on_demand(s_od),
    .bus_en(bus_en), .gen_en(gen_en), .src_en(src_en)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt_rand(logic [31:0] x);
    logic [31:0] y = x;
    y ^= y << 13; y ^= y >> 17; y ^= y << 5;
    return y;
  endfunction

  // Independent model: scatter requests into generator/source demand.
  logic [NP-1:0] e_bus;
  logic [NG-1:0] e_gen, e_gdem;
  logic [NS-1:0] e_src, e_sdem;
  task automatic model();
    e_gdem = '0; e_sdem = '0;
    for (int p = 0; p < NP; p++) begin
      int k = int'(gsel[p*GW +: GW]);
      if (k < NG && gen_req[p]) e_gdem[k] = 1'b1;
    end
    case (sleep_lvl)
      2'd0: e_bus = '1;
      2'd1: e_bus = bus_req | FREE;
      default: e_bus = bus_req;
    endcase
    for (int g = 0; g < NG; g++) begin
      if (sleep_lvl != 2'd3) e_gen[g] = (g == 0) ? 1'b1 : e_gdem[g];
      else if (g == 0) e_gen[g] = (bus_req != '0) || (g_stby[0] && e_gdem[0]);
      else e_gen[g] = g_stby[g] && e_gdem[g];
    end
    for (int g = 0; g < NG; g++) begin
      int k = int'(ssel[g*SW +: SW]);
      if (k < NS && e_gen[g]) e_sdem[k] = 1'b1;
    end
    for (int s = 0; s < NS; s++) begin
      if (sleep_lvl == 2'd3 && !s_stby[s]) e_src[s] = 1'b0;
      else if (s_od[s]) e_src[s] = e_sdem[s];
      else e_src[s] = 1'b1;
    end
  endtask

  task automatic check_all();
    string bt, gt0, gt, st;
    bt  = (sleep_lvl == 2'd0) ? "R3" : (sleep_lvl == 2'd1) ? "R4" : "R5";
    gt0 = (sleep_lvl == 2'd3) ? "R9" : "R7";
    gt  = (sleep_lvl == 2'd3) ? "R8" : "R6";
    chk(bt, 32'(bus_en), 32'(e_bus));
    chk(gt0, 32'(gen_en[0]), 32'(e_gen[0]));
    chk(gt, 32'(gen_en[NG-1:1]), 32'(e_gen[NG-1:1]));
    for (int s = 0; s < NS; s++) begin
      st = (sleep_lvl == 2'd3) ? "R12" : (s_od[s] ? "R10" : "R11");
      chk(st, 32'(src_en[s]), 32'(e_src[s]));
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    gen_req = '1; bus_req = '1; g_stby = '1; s_stby = '1;
    repeat (3) @(negedge clk);
    chk("R1", 32'({bus_en, gen_en, src_en}), 32'h0);
    rst_n = 1'b1;

    // R2: a new request appears only after the next edge.
    @(negedge clk);
    sleep_lvl = 2'd2; gen_req = '0; bus_req = '0; gsel = '0; ssel = '0; s_od = '1;
    @(negedge clk);
    chk("R2", 32'(gen_en), 32'b001);
    chk("R2", 32'(src_en), 32'b001);
    gen_req = 4'b0001; gsel = {2'd0, 2'd0, 2'd0, 2'd2}; ssel = {2'd1, 2'd0, 2'd0};
    #1;
    chk("R2", 32'(gen_en), 32'b001);
    @(negedge clk);
    chk("R2", 32'(gen_en), 32'b101);
    chk("R2", 32'(src_en), 32'b011);

    // Sweep: every level, pseudo-random fields.
    for (int lv = 0; lv < 4; lv++) begin
      for (int i = 0; i < 400; i++) begin
        lfsr = nxt_rand(lfsr);
        sleep_lvl = 2'(lv);
        gen_req = lfsr[3:0]; bus_req = (i % 3 == 0) ? '0 : lfsr[7:4];
        gsel = lfsr[15:8]; ssel = lfsr[21:16];
        g_stby = lfsr[24:22]; s_stby = lfsr[27:25]; s_od = lfsr[30:28];
        model();
        @(negedge clk);
        check_all();
      end
    end
    finish_run();
  end
endmodule